// File: doc/BRIEF.md
# E3 Transmit Overhead Insertion Multiplexer

This block builds the outbound serial E3 bit stream one bit per transmit clock. It places a frame of 1536 bits: twelve overhead bits at the head of the frame and 1524 payload bits after them. The first ten overhead positions carry a fixed frame alignment pattern that no input can change. Position 11 carries the alarm bit, which reports a far-end receive failure. Position 12 carries the national bit, which transports either a user data link or a path maintenance data link.

Payload is pulled from an upstream source through a ready strobe. The strobe stays low during the overhead slots, so no payload bit is used up there. An external overhead port gets three timing outputs: a pulse at the frame start, an enable over the two positions that can be sourced from outside, and an overhead clock that marks when a sampled bit reaches the line. It accepts two inputs back: a data bit and an insert request. When the insert request is low, the alarm bit follows the FERF input. The national bit then follows either the data-link controller input or an idle level of one, depending on a source select.

Every output decision is made from the position counter in the same cycle that the inputs are sampled. The serial line register adds one cycle of latency between sampling a bit and showing it on the line.

Top module: `e3_oh_mux`

## Requirements
- R1: `oh_frame` is high for exactly one cycle out of every 1536 cycles while out of reset. That cycle is frame position 1.
- R2: The line output for positions 1 to 10 is the pattern 1,1,1,1,0,1,0,0,0,0, in that order. Neither `oh_ins` nor `oh_data` changes it.
- R3: `oh_en` is high exactly during positions 11 and 12 and low at every other position.
- R4: `payload_rdy` is low at positions 1 to 12 and high at positions 13 to 1536. The `payload_in` value sampled in a ready cycle appears on `line_out` one cycle later.
- R5: The bit at position 11 (alarm) is `oh_data` when `oh_ins` is high in that cycle, and `ferf_in` otherwise.
- R6: The bit at position 12 (national) is `dl_in` when `oh_ins` is low and `n_sel` is 0 (maintenance link taken from the data-link controller).
- R7: The bit at position 12 is `oh_data` whenever `oh_ins` is high in that cycle, for either value of `n_sel`.
- R8: The bit at position 12 is 1 (idle) when `oh_ins` is low and `n_sel` is 1 (national bit reserved for the external port).
- R9: Reset is synchronous and active high. While it is held, `oh_frame`, `oh_en`, `payload_rdy` and `oh_clk` are low and `line_out` is low after the first reset edge. The first cycle after reset is released is position 1.
- R10: `oh_clk` is high in exactly those cycles that directly follow a cycle with `oh_en` high.
- R11: Every bit on `line_out` is the bit chosen for the position of the previous cycle, taken from the inputs sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| payload_in | input | 1 | Payload bit, sampled while `payload_rdy` is high |
| payload_rdy | output | 1 | Payload request strobe, low in overhead slots |
| ferf_in | input | 1 | Internal far-end receive failure indication for the alarm bit |
| dl_in | input | 1 | Data-link controller bit for the national position |
| n_sel | input | 1 | National bit source: 0 data-link input, 1 external port |
| oh_data | input | 1 | External overhead data bit |
| oh_ins | input | 1 | External insert request, honoured only at positions 11 and 12 |
| oh_frame | output | 1 | Frame start pulse at position 1 |
| oh_en | output | 1 | High over the externally sourceable positions 11 and 12 |
| oh_clk | output | 1 | High in the cycle after each `oh_en` cycle |
| line_out | output | 1 | Serial E3 output |

## Verification
The three strobes `oh_frame`, `oh_en` and `payload_rdy` are combinational decodes of the position counter. They are due in the same cycle as the position they describe. `line_out` and `oh_clk` come from registers, so each is due exactly one clock after the inputs or the enable it depends on. The bench drives inputs on the falling edge and compares every output on the next falling edge. It keeps a behavioural position count and a one-deep store of the expected line bit, which it captures from the inputs in force at the rising edge. This way each expected value is compared in the cycle where the design's registers make it visible.

// File: rtl/e3_oh_pkg.sv
package e3_oh_pkg;

    localparam int unsigned FRAME_BITS = 1536;
    localparam int unsigned FAS_LEN    = 10;
    localparam int unsigned OH_BITS    = FAS_LEN + 2;
    localparam int unsigned POS_W      = $clog2(FRAME_BITS);

    localparam logic [FAS_LEN-1:0] FAS_PATTERN = 10'b1111010000;

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [1:0] {
        SLOT_FAS     = 2'd0,
        SLOT_ALARM   = 2'd1,
        SLOT_NAT     = 2'd2,
        SLOT_PAYLOAD = 2'd3
    } slot_e;

endpackage

// File: rtl/e3_frame_cnt.sv
module e3_frame_cnt
    import e3_oh_pkg::*;
#(
    parameter int unsigned FRAME_LEN = FRAME_BITS,
    parameter int unsigned FAS_W     = FAS_LEN,
    localparam int unsigned CNT_W    = $clog2(FRAME_LEN),
    localparam int unsigned OH_LEN   = FAS_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] pos,
    output slot_e            slot,
    output logic             frame_stb,
    output logic             en_stb,
    output logic             rdy_stb
);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } cnt_state_t;

    localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] ALARM_POS = CNT_W'(FAS_W);
    localparam logic [CNT_W-1:0] NAT_POS   = CNT_W'(FAS_W + 1);
    localparam logic [CNT_W-1:0] PAY_POS   = CNT_W'(OH_LEN);

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pos = '0;
        end else if (st_q.pos == LAST_POS) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        if (st_q.pos < ALARM_POS) begin
            slot = SLOT_FAS;
        end else if (st_q.pos == ALARM_POS) begin
            slot = SLOT_ALARM;
        end else if (st_q.pos == NAT_POS) begin
            slot = SLOT_NAT;
        end else begin
            slot = SLOT_PAYLOAD;
        end
    end

    assign pos       = st_q.pos;
    assign frame_stb = !rst && (st_q.pos == '0);
    assign en_stb    = !rst && ((slot == SLOT_ALARM) || (slot == SLOT_NAT));
    assign rdy_stb   = !rst && (st_q.pos >= PAY_POS);

endmodule

// File: rtl/e3_oh_select.sv
module e3_oh_select
    import e3_oh_pkg::*;
#(
    parameter int unsigned FAS_W                = FAS_LEN,
    parameter logic [FAS_W-1:0] FAS_BITS        = FAS_PATTERN,
    parameter int unsigned CNT_W                = POS_W
) (
    input  logic [CNT_W-1:0] pos,
    input  slot_e            slot,
    input  logic             payload_in,
    input  logic             ferf_in,
    input  logic             dl_in,
    input  logic             n_sel,
    input  logic             oh_data,
    input  logic             oh_ins,
    output logic             bit_out
);

    logic [FAS_W-1:0] fas_by_pos;
    logic             fas_bit;
    logic             alarm_bit;
    logic             nat_bit;

    // Reverse the pattern so index equals frame position (first bit sent first).
    for (genvar gi = 0; gi < FAS_W; gi++) begin : g_fas
        assign fas_by_pos[gi] = FAS_BITS[FAS_W-1-gi];
    end

    always_comb begin
        fas_bit = 1'b0;
        for (int i = 0; i < FAS_W; i++) begin
            if (pos == CNT_W'(i)) begin
                fas_bit = fas_by_pos[i];
            end
        end
    end

    always_comb begin
        alarm_bit = oh_ins ? oh_data : ferf_in;
    end

    always_comb begin
        if (oh_ins) begin
            nat_bit = oh_data;
        end else if (n_sel) begin
            nat_bit = 1'b1;
        end else begin
            nat_bit = dl_in;
        end
    end

    always_comb begin
        unique case (slot)
            SLOT_FAS:     bit_out = fas_bit;
            SLOT_ALARM:   bit_out = alarm_bit;
            SLOT_NAT:     bit_out = nat_bit;
            SLOT_PAYLOAD: bit_out = payload_in;
            default:      bit_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/e3_oh_mux.sv
module e3_oh_mux
    import e3_oh_pkg::*;
#(
    parameter int unsigned FRAME_LEN        = FRAME_BITS,
    parameter int unsigned FAS_W            = FAS_LEN,
    parameter logic [FAS_W-1:0] FAS_BITS    = FAS_PATTERN
) (
    input  logic clk,
    input  logic rst,
    input  logic payload_in,
    output logic payload_rdy,
    input  logic ferf_in,
    input  logic dl_in,
    input  logic n_sel,
    input  logic oh_data,
    input  logic oh_ins,
    output logic oh_frame,
    output logic oh_en,
    output logic oh_clk,
    output logic line_out
);

    localparam int unsigned CNT_W = $clog2(FRAME_LEN);

    typedef struct packed {
        logic line;
        logic ohclk;
    } out_state_t;

    logic [CNT_W-1:0] pos;
    slot_e            slot;
    logic             frame_stb;
    logic             en_stb;
    logic             rdy_stb;
    logic             sel_bit;

    out_state_t st_d, st_q;

    e3_frame_cnt #(
        .FRAME_LEN (FRAME_LEN),
        .FAS_W     (FAS_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .pos       (pos),
        .slot      (slot),
        .frame_stb (frame_stb),
        .en_stb    (en_stb),
        .rdy_stb   (rdy_stb)
    );

    e3_oh_select #(
        .FAS_W    (FAS_W),
        .FAS_BITS (FAS_BITS),
        .CNT_W    (CNT_W)
    ) u_sel (
        .pos        (pos),
        .slot       (slot),
        .payload_in (payload_in),
        .ferf_in    (ferf_in),
        .dl_in      (dl_in),
        .n_sel      (n_sel),
        .oh_data    (oh_data),
        .oh_ins     (oh_ins),
        .bit_out    (sel_bit)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.line  = 1'b0;
            st_d.ohclk = 1'b0;
        end else begin
            st_d.line  = sel_bit;
            st_d.ohclk = en_stb;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign payload_rdy = rdy_stb;
    assign oh_frame    = frame_stb;
    assign oh_en       = en_stb;
    assign oh_clk      = st_q.ohclk;
    assign line_out    = st_q.line;

endmodule

// File: rtl/e3_oh_mux_chk.sv
module e3_oh_mux_chk (
    input logic clk,
    input logic rst,
    input logic payload_rdy,
    input logic oh_frame,
    input logic oh_en,
    input logic oh_clk,
    input logic line_out
);

    AST_FRAME_ALONE: assert property (@(posedge clk) disable iff (rst)
        oh_frame |-> (!oh_en && !payload_rdy)); // R1

    AST_FAS_HEAD: assert property (@(posedge clk) disable iff (rst)
        $past(oh_frame) |-> line_out); // R2

    AST_EN_PAIR: assert property (@(posedge clk) disable iff (rst)
        (oh_en && $past(oh_en)) |=> !oh_en); // R3

    AST_EN_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(oh_en) |=> oh_en); // R3

    AST_RDY_EXCL: assert property (@(posedge clk) disable iff (rst)
        payload_rdy |-> (!oh_en && !oh_frame)); // R4

    AST_OHCLK_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        oh_clk == $past(oh_en)); // R10

    always_comb begin
        if (rst) begin
            AST_RST_QUIET: assert (!oh_frame && !oh_en && !payload_rdy); // R9
        end
    end

endmodule

bind e3_oh_mux e3_oh_mux_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .payload_rdy (payload_rdy),
    .oh_frame    (oh_frame),
    .oh_en       (oh_en),
    .oh_clk      (oh_clk),
    .line_out    (line_out)
);

// File: tb/e3_oh_mux_bench.sv
module e3_oh_mux_bench;

    localparam int FRAME = 1536;
    localparam logic [9:0] FAS = 10'b1111010000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic payload_in = 1'b0;
    logic ferf_in = 1'b0;
    logic dl_in = 1'b0;
    logic n_sel = 1'b0;
    logic oh_data = 1'b0;
    logic oh_ins = 1'b0;
    logic payload_rdy, oh_frame, oh_en, oh_clk, line_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int ref_pos = 0;
    logic exp_line = 1'b0;
    logic prev_en = 1'b0;
    string line_tag = "R9";
    logic [15:0] frame_seen = '0;

    always #10 clk = ~clk;

    e3_oh_mux u_e3_oh_mux (
        .clk         (clk),
        .rst         (rst),
        .payload_in  (payload_in),
        .payload_rdy (payload_rdy),
        .ferf_in     (ferf_in),
        .dl_in       (dl_in),
        .n_sel       (n_sel),
        .oh_data     (oh_data),
        .oh_ins      (oh_ins),
        .oh_frame    (oh_frame),
        .oh_en       (oh_en),
        .oh_clk      (oh_clk),
        .line_out    (line_out)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s pos=%0d actual=%b expected=%b", tag, what, ref_pos, act, exp);
        end
    endtask

    function automatic logic model_bit(input int p);
        if (p < 10)       return FAS[9-p];
        else if (p == 10) return oh_ins ? oh_data : ferf_in;
        else if (p == 11) return oh_ins ? oh_data : (n_sel ? 1'b1 : dl_in);
        else              return payload_in;
    endfunction

    function automatic string model_tag(input int p);
        if (p < 10)       return "R2";
        else if (p == 10) return "R5";
        else if (p == 11) return oh_ins ? "R7" : (n_sel ? "R8" : "R6");
        else              return "R4";
    endfunction

    // mode 0: no inserts, n_sel 0; mode 1: no inserts, n_sel 1; mode 2: everything random
    task automatic step(input logic r, input int mode);
        logic exp_frame, exp_en, exp_rdy, nxt;
        string ntag;
        @(negedge clk);
        exp_frame = !rst && (ref_pos == 0);
        exp_en    = !rst && (ref_pos == 10 || ref_pos == 11);
        exp_rdy   = !rst && (ref_pos >= 12);
        check(oh_frame, exp_frame, rst ? "R9" : "R1", "oh_frame");
        check(oh_en, exp_en, rst ? "R9" : "R3", "oh_en");
        check(payload_rdy, exp_rdy, rst ? "R9" : "R4", "payload_rdy");
        check(oh_clk, prev_en, "R10", "oh_clk");
        check(line_out, exp_line, line_tag, "line_out R11");
        rst        = r;
        payload_in = 1'($urandom);
        ferf_in    = 1'($urandom);
        dl_in      = 1'($urandom);
        oh_data    = 1'($urandom);
        n_sel      = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1 : 1'($urandom);
        oh_ins     = (mode == 2) ? 1'($urandom) : 1'b0;
        nxt  = r ? 1'b0 : model_bit(ref_pos);
        ntag = r ? "R9" : model_tag(ref_pos);
        prev_en = !r && (ref_pos == 10 || ref_pos == 11);
        @(posedge clk);
        exp_line = nxt;
        line_tag = ntag;
        if (r) ref_pos = 0;
        else   ref_pos = (ref_pos + 1) % FRAME;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        for (int i = 0; i < 4; i++) step(1'b1, 0);
        for (int i = 0; i < FRAME + 20; i++) step(1'b0, 0);
        for (int i = 0; i < FRAME; i++) step(1'b0, 1);
        for (int i = 0; i < 2 * FRAME; i++) step(1'b0, 2);
        for (int i = 0; i < 3; i++) step(1'b1, 2);   // R9 mid-frame reset
        for (int i = 0; i < FRAME + 40; i++) step(1'b0, 2);
        step(1'b0, 2);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule